// File: doc/BRIEF.md
# Data-Space Address Generator

This block works out the data-space address used by a load or store in a small 8-bit RISC core. It holds three 16-bit pointer registers, called X, Y and Z. The core picks one of six addressing modes and pulses `start`. One clock later the block presents the effective address with a valid flag. In the same cycle it reports the new value of the selected pointer, if the mode changes that pointer.

The core owns the register-file pairs that the pointers mirror. A parallel load strobe copies all three pointers into the block at once. The write-back outputs then let the core keep its register copy in step after a post-increment or a pre-decrement access.

I/O-direct accesses carry a 6-bit port number. The block moves this number past the 32 general registers, so the port lands at its data-space location. The extended I/O area can only be reached through the direct and indirect modes.

Top module: `data_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `ea_valid` and `wb_en` are 0, and `ea`, `wb_sel` and `wb_val` are 0. The X, Y and Z pointers reset to 0.
- R2: A high `ptr_load` copies `x_in`, `y_in` and `z_in` into X, Y and Z at the clock edge. If a pointer update from a post-increment or pre-decrement happens in the same cycle, the load wins.
- R3: Mode code 0 (I/O direct) issues `ea` = `io_addr` + 0x20, zero-extended. `ptr_sel` is ignored and no pointer changes.
- R4: Mode code 1 (data direct) issues `ea` = `dir_addr`. No pointer changes.
- R5: Mode code 2 (indirect) issues the current value of the selected pointer. The `ptr_sel` codes are 0 = X, 1 = Y and 2 = Z. The pointer is not modified.
- R6: Mode code 3 (displacement) with Y or Z issues the pointer plus `disp`, zero-extended, modulo 2^16, and leaves the pointer unchanged. With X, or with `ptr_sel` = 3, it gives no valid address and no write-back.
- R7: Mode code 4 (post-increment) issues the pointer value from before the update. The new value, pointer + 1 modulo 2^16, is stored and reported on `wb_val`, with `wb_en` high and `wb_sel` naming the pointer.
- R8: Mode code 5 (pre-decrement) stores pointer − 1 modulo 2^16. That same value is issued on `ea` and reported on `wb_val`, with `wb_en` high.
- R9: Results are registered. `ea_valid` and `wb_en` are high only in the cycle after an accepted `start`, and `wb_en` is high only for modes 4 and 5. A `start` in the next cycle already sees the updated pointer.
- R10: Mode codes 6 and 7, and the pointer modes (2, 4, 5) with `ptr_sel` = 3, give no valid address, no write-back and no pointer change. In that case `ea`, `wb_sel` and `wb_val` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_load | input | 1 | Parallel load strobe for all pointers |
| x_in | input | 16 | Load value for X |
| y_in | input | 16 | Load value for Y |
| z_in | input | 16 | Load value for Z |
| start | input | 1 | Compute an address this cycle |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| io_addr | input | 6 | I/O port number |
| dir_addr | input | 16 | Direct data address |
| disp | input | 6 | Unsigned displacement |
| ea | output | 16 | Effective data-space address |
| ea_valid | output | 1 | `ea` belongs to the previous cycle's `start` |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer being written back |
| wb_val | output | 16 | New pointer value |

## Verification
Every output is due exactly one clock after the cycle in which `start` or `ptr_load` was presented. A pointer change shows up in the next access, one cycle after that. The bench drives each stimulus on the falling edge and advances a behavioural model of the pointers and outputs by one step per rising edge. It compares all five outputs at the next falling edge, so every comparison falls in the cycle where the result is due. Pointer state that the outputs do not show is brought out through indirect accesses that follow the stimulus.

// File: rtl/data_addr_gen.sv
module data_addr_gen #(
  parameter int AW     = 16,
  parameter int IOW    = 6,
  parameter int DSPW   = 6,
  parameter int IO_OFS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_load,
  input  logic [AW-1:0] x_in,
  input  logic [AW-1:0] y_in,
  input  logic [AW-1:0] z_in,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [1:0]    ptr_sel,
  input  logic [IOW-1:0]  io_addr,
  input  logic [AW-1:0] dir_addr,
  input  logic [DSPW-1:0] disp,
  output logic [AW-1:0] ea,
  output logic          ea_valid,
  output logic          wb_en,
  output logic [1:0]    wb_sel,
  output logic [AW-1:0] wb_val
);
  localparam logic [2:0] M_IO = 3'd0, M_DIR = 3'd1, M_IND = 3'd2,
                         M_DSP = 3'd3, M_INC = 3'd4, M_DEC = 3'd5;
  localparam logic [AW-1:0] IO_BASE = AW'(IO_OFS);

  logic [AW-1:0] px, py, pz, cur;
  logic [AW-1:0] nxt_ea, nxt_ptr;
  logic          ok, upd, sel_ok;

  assign cur    = (ptr_sel == 2'd0) ? px : (ptr_sel == 2'd1) ? py : pz;
  assign sel_ok = (ptr_sel != 2'd3);

  always_comb begin
    nxt_ea  = cur;
    nxt_ptr = cur;
    ok      = 1'b0;
    upd     = 1'b0;
    case (mode)
      M_IO:  begin nxt_ea = AW'(io_addr) + IO_BASE; ok = 1'b1; end
      M_DIR: begin nxt_ea = dir_addr; ok = 1'b1; end
      M_IND: ok = sel_ok;
      M_DSP: begin
        nxt_ea = cur + AW'(disp);
        ok     = (ptr_sel == 2'd1) || (ptr_sel == 2'd2);
      end
      M_INC: begin nxt_ptr = cur + 1'b1; ok = sel_ok; upd = 1'b1; end
      M_DEC: begin
        nxt_ptr = cur - 1'b1;
        nxt_ea  = nxt_ptr;
        ok      = sel_ok;
        upd     = 1'b1;
      end
      default: ok = 1'b0;
    endcase
  end

  wire go = start && ok;
  wire wr = go && upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px <= '0; py <= '0; pz <= '0;
    end else if (ptr_load) begin
      px <= x_in; py <= y_in; pz <= z_in;
    end else if (wr) begin
      case (ptr_sel)
        2'd0:    px <= nxt_ptr;
        2'd1:    py <= nxt_ptr;
        default: pz <= nxt_ptr;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea       <= '0;
      ea_valid <= 1'b0;
      wb_en    <= 1'b0;
      wb_sel   <= 2'd0;
      wb_val   <= '0;
    end else begin
      ea_valid <= go;
      wb_en    <= wr;
      if (go) ea <= nxt_ea;
      if (wr) begin
        wb_sel <= ptr_sel;
        wb_val <= nxt_ptr;
      end
    end
  end
endmodule

// File: rtl/data_addr_gen_chk.sv
module data_addr_gen_chk #(
  parameter int AW   = 16,
  parameter int IOW  = 6,
  parameter int DSPW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [2:0]      mode,
  input logic [1:0]      ptr_sel,
  input logic [IOW-1:0]  io_addr,
  input logic [DSPW-1:0] disp,
  input logic [AW-1:0]   ea,
  input logic            ea_valid,
  input logic            wb_en,
  input logic [AW-1:0]   wb_val
);
  // R9
  valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> $past(start));

  // R9
  wb_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> ea_valid);

  // R7
  post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && $past(mode) == 3'd4) |-> (wb_en && wb_val == AW'(ea + 1'b1)));

  // R8
  pre_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && $past(mode) == 3'd5) |-> (wb_en && wb_val == ea));

  // R3
  io_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && $past(mode) == 3'd0) |-> (!wb_en && ea == AW'($past(io_addr)) + AW'(32)));

  // R6
  disp_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 3'd3 && ptr_sel == 2'd0) |=> !ea_valid);

  // R10
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode[2:1] == 2'b11) |=> (!ea_valid && !wb_en));

  logic unused_disp;
  assign unused_disp = ^disp;
endmodule

bind data_addr_gen data_addr_gen_chk #(.AW(AW), .IOW(IOW), .DSPW(DSPW)) u_chk (.*);

// File: tb/sim_data_addr_gen.sv
module sim_data_addr_gen;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        ptr_load = 0, start = 0;
  logic [15:0] x_in = 0, y_in = 0, z_in = 0, dir_addr = 0;
  logic [2:0]  mode = 0;
  logic [1:0]  ptr_sel = 0;
  logic [5:0]  io_addr = 0, disp = 0;
  logic [15:0] ea, wb_val;
  logic        ea_valid, wb_en;
  logic [1:0]  wb_sel;

  int checks = 0, fails = 0;
  bit done = 0;

  int mp[3];
  int e_ea = 0, e_vld = 0, e_wb = 0, e_sel = 0, e_val = 0;
  string tag = "R1";

  data_addr_gen u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic compare();
    chk({tag, " valid"}, ea_valid, e_vld);
    chk({tag, " wb_en"}, wb_en, e_wb);
    chk({tag, " ea"}, ea, e_ea);
    chk({tag, " wb_sel"}, wb_sel, e_sel);
    chk({tag, " wb_val"}, wb_val, e_val);
  endtask

  task automatic step(bit st, int md, int sel, int io = 0, int da = 0, int dp = 0,
                      bit ld = 0, int lx = 0, int ly = 0, int lz = 0);
    int cur, e, nv;
    bit ok, up;
    start = st; mode = 3'(md); ptr_sel = 2'(sel); io_addr = 6'(io);
    dir_addr = 16'(da); disp = 6'(dp); ptr_load = ld;
    x_in = 16'(lx); y_in = 16'(ly); z_in = 16'(lz);
    cur = (sel < 3) ? mp[sel] : 0;
    ok = 0; up = 0; e = 0; nv = cur;
    case (md)
      0: begin e = io + 32; ok = 1; tag = "R3"; end
      1: begin e = da; ok = 1; tag = "R4"; end
      2: begin e = cur; ok = (sel < 3); tag = "R5"; end
      3: begin e = (cur + dp) % 65536; ok = (sel == 1 || sel == 2); tag = "R6"; end
      4: begin e = cur; nv = (cur + 1) % 65536; ok = (sel < 3); up = 1; tag = "R7"; end
      5: begin nv = (cur + 65535) % 65536; e = nv; ok = (sel < 3); up = 1; tag = "R8"; end
      default: tag = "R10";
    endcase
    if (!ok && md < 6) tag = {tag, "/R10"};
    if (ld) tag = {tag, "/R2"};
    e_vld = st && ok;
    e_wb  = e_vld && up;
    if (e_vld) e_ea = e;
    if (e_wb) begin e_sel = sel; e_val = nv; end
    if (ld) begin mp[0] = lx % 65536; mp[1] = ly % 65536; mp[2] = lz % 65536; end
    else if (e_wb) mp[sel] = nv;
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    mp = '{0, 0, 0};
    repeat (3) @(negedge clk);
    tag = "R1 reset";
    compare();
    rst_n = 1;
    // R1: pointers start at zero
    step(1, 2, 0); step(1, 2, 1); step(1, 2, 2);
    // R2: parallel load, then read back
    step(0, 0, 0, 0, 0, 0, 1, 16'h0100, 16'h0200, 16'hFFFF);
    step(1, 2, 0); step(1, 2, 1); step(1, 2, 2);
    // R3
    step(1, 0, 3, 0); step(1, 0, 0, 63); step(1, 0, 1, 17);
    // R4
    step(1, 1, 0, 0, 16'hBEEF); step(1, 1, 3, 0, 16'h0060);
    // R6
    step(1, 3, 1, 0, 0, 63); step(1, 3, 2, 0, 0, 5); step(1, 3, 0, 0, 0, 7);
    step(1, 3, 3, 0, 0, 7); step(1, 2, 1);
    // R7: wrap of Z from FFFF, then back-to-back on Y (R9)
    step(1, 4, 2); step(1, 2, 2);
    step(1, 4, 1); step(1, 4, 1); step(1, 2, 1);
    // R8: X wraps below zero
    step(0, 0, 0, 0, 0, 0, 1, 0, 16'h0010, 16'h0020);
    step(1, 5, 0); step(1, 5, 0); step(1, 2, 0);
    // R2: load beats a same-cycle post-increment
    step(1, 4, 1, 0, 0, 0, 1, 16'h1111, 16'h2222, 16'h3333);
    step(1, 2, 1);
    // R10: unused codes and pointer select 3
    step(1, 6, 0); step(1, 7, 2); step(1, 4, 3); step(1, 5, 3);
    step(1, 2, 0); step(1, 2, 2);
    // R9: no start, no valid
    step(0, 4, 0); step(0, 1, 0, 0, 16'h1234);
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 1), $urandom_range(0, 7), $urandom_range(0, 3),
           $urandom_range(0, 63), $urandom_range(0, 65535), $urandom_range(0, 63),
           ($urandom_range(0, 15) == 0), $urandom_range(0, 65535),
           $urandom_range(0, 65535), $urandom_range(0, 65535));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9: watchdog expired, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule